// File: doc/BRIEF.md
# Polled Quadrant Flag Bus Sequencer

This block drives a narrow almost-full status bus for a device that holds 32 queues, grouped into four quadrants of eight queues. The per-queue flags come in as one active-low vector; the block places one quadrant's eight flags at a time on an 8-bit output bus. Flag bit `i` of the bus stands for queue `quadrant*8 + i`, where quadrants are numbered 0 to 3 internally (first to fourth).

A static mode input chooses how the shown quadrant is picked. In direct mode the host pulses a strobe together with a write address, and the quadrant named by the address is held until the next strobe. In polled mode the quadrants are shown in turn, one per write-clock edge. Several devices can share one bus: a token passed round a ring tells the next device to start its own four-quadrant rotation. A sync output marks the cycle when this device's first quadrant is on the bus. A polled device drives the bus only while it holds the token. The device configured as master starts the ring on its own after reset.

Top module: `flag_bus_seq`

## Requirements
- R1: While reset is low at a clock edge, the next cycle shows flag bus all ones, output enable low, sync low and token output low.
- R2: In direct mode, when the strobe is high at an edge, the quadrant in address bits [4:3] (0 = first) is latched and that edge loads the bus with flag bits quadrant*8 .. quadrant*8+7, bus bit i from flag quadrant*8+i.
- R3: In direct mode without a strobe, the latched quadrant is kept and every edge reloads the bus with that quadrant's current flags. Output enable is high from the first edge after reset. The quadrant after reset is the first one.
- R4: In direct mode, sync and token output stay low.
- R5: In polled mode the strobe and address have no effect on the bus, the enable, sync or token output.
- R6: In polled mode a master device loads the first quadrant at the first edge after reset. A device holding the token then loads the second, third and fourth quadrants on the next three edges, with output enable high.
- R7: Sync is high exactly in the cycles when this device's first quadrant is on the bus.
- R8: Token output is high exactly in the cycles when this device's fourth quadrant is on the bus.
- R9: When token input is high at an edge in polled mode, that edge loads the first quadrant, even in the middle of a rotation.
- R10: In polled mode, a device without the token holds output enable low and the bus all ones. It releases the bus at the edge after its fourth quadrant unless the token input is high.
- R11: With token output looped back to token input, a single master repeats the four quadrants with period four: the fifth edge shows the first quadrant again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_w | input | 1 | Write clock |
| rst_n | input | 1 | Synchronous active-low reset |
| afull_n | input | 32 | Active-low almost-full flag per queue |
| wr_addr | input | 5 | Queue address; bits [4:3] name the quadrant |
| strobe | input | 1 | Direct-mode quadrant select strobe |
| mode_polled | input | 1 | Static mode: 1 polled, 0 direct |
| is_master | input | 1 | Static: this device starts the token ring |
| tok_in | input | 1 | Token from the previous device in the ring |
| flag_bus | output | 8 | Active-low flags of the shown quadrant |
| flag_oe | output | 1 | Bus drive enable (high = drive) |
| sync | output | 1 | High while the first quadrant is shown |
| tok_out | output | 1 | High while the fourth quadrant is shown |

## Verification
The bench goes after the token wrap-around. A design that counts five steps, or that fails to re-arm from its own looped token, would show a gap cycle or a stale quadrant on the fifth edge. A token arriving mid-rotation must restart at the first quadrant; a design that ignores it would hold the bus in two devices at once. Strobes sent in polled mode must not move the display; a leak would appear as a wrong quadrant once the device returns to direct mode. A non-master must stay off the bus until its token arrives. A design that skips the release after the fourth quadrant would keep its enable high and clash with the next device.

// File: rtl/flagseq_pkg.sv
// Package: shared types for the flag bus sequencer.
// Assumes: the mode input is static between resets.
package flagseq_pkg;
    typedef enum logic {
        MODE_DIRECT = 1'b0,
        MODE_POLLED = 1'b1
    } fmode_e;

    // Number of bits needed to index n items (at least one).
    function automatic int idx_bits(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction
endpackage

// File: rtl/fbs_poll_seq.sv
// Module: fbs_poll_seq
// Holds the polled-mode rotation state: whether this device owns the bus and
// which quadrant it shows. It gives the next-state values to the bus register.
// Assumes: en is static between resets; tok_in is synchronous to clk.
module fbs_poll_seq #(
    parameter int QUADS  = 4,
    parameter int QSEL_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              is_master,
    input  logic              tok_in,
    output logic              nxt_act,
    output logic [QSEL_W-1:0] nxt_idx,
    output logic              sync,
    output logic              tok_out
);
    localparam logic [QSEL_W-1:0] LAST = QSEL_W'(QUADS - 1);

    logic              act_q;
    logic [QSEL_W-1:0] idx_q;
    logic              boot_q;
    logic              start;

    // Start of a rotation: token arrival or master's first edge.
    assign start = tok_in | (boot_q & is_master);

    // Next rotation state: restart, step, or release after the last quadrant.
    always_comb begin
        nxt_act = act_q;
        nxt_idx = idx_q;
        if (!en) begin
            nxt_act = 1'b0;
            nxt_idx = '0;
        end else if (start) begin
            nxt_act = 1'b1;
            nxt_idx = '0;
        end else if (act_q) begin
            if (idx_q == LAST) begin
                nxt_act = 1'b0;
            end else begin
                nxt_idx = idx_q + 1'b1;
            end
        end
    end

    // Rotation state registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q  <= 1'b0;
            idx_q  <= '0;
            boot_q <= 1'b1;
        end else begin
            act_q  <= nxt_act;
            idx_q  <= nxt_idx;
            boot_q <= 1'b0;
        end
    end

    // Markers for the first and last quadrant on the bus.
    assign sync    = en & act_q & (idx_q == '0);
    assign tok_out = en & act_q & (idx_q == LAST);
endmodule

// File: rtl/fbs_dir_sel.sv
// Module: fbs_dir_sel
// Holds the quadrant chosen in direct mode. A strobe loads the quadrant field
// of the address. In polled mode the strobe is ignored.
// Assumes: the quadrant field is the top QSEL_W bits of the address.
module fbs_dir_sel #(
    parameter int ADDR_W = 5,
    parameter int QSEL_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              strobe,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic [QSEL_W-1:0] nxt_sel
);
    logic [QSEL_W-1:0] sel_q;

    // Next selection: strobe in direct mode takes the address quadrant.
    always_comb begin
        nxt_sel = sel_q;
        if (en && strobe) begin
            nxt_sel = wr_addr[ADDR_W-1 -: QSEL_W];
        end
    end

    // Selection register with synchronous reset to the first quadrant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else begin
            sel_q <= nxt_sel;
        end
    end
endmodule

// File: rtl/fbs_flag_mux.sv
// Module: fbs_flag_mux
// Cuts the flag vector into quadrant slices and registers the chosen slice onto
// the bus. When not shown, the bus idles at all ones and the enable is low.
// Assumes: QUEUES is a multiple of QUADS.
module fbs_flag_mux #(
    parameter int QUEUES = 32,
    parameter int QUADS  = 4,
    parameter int QSEL_W = 2,
    parameter int GRP    = QUEUES / QUADS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [QUEUES-1:0] afull_n,
    input  logic              show,
    input  logic [QSEL_W-1:0] quad,
    output logic [GRP-1:0]    flag_bus,
    output logic              flag_oe
);
    logic [GRP-1:0] slice [QUADS];
    logic [GRP-1:0] pick;

    // One slice per quadrant.
    for (genvar g = 0; g < QUADS; g++) begin : g_slice
        assign slice[g] = afull_n[g*GRP +: GRP];
    end

    // Pick the slice of the requested quadrant.
    always_comb begin
        pick = '1;
        for (int k = 0; k < QUADS; k++) begin
            if (quad == QSEL_W'(k)) pick = slice[k];
        end
    end

    // Bus and enable registers; idle value is all ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_bus <= '1;
            flag_oe  <= 1'b0;
        end else begin
            flag_bus <= show ? pick : '1;
            flag_oe  <= show;
        end
    end
endmodule

// File: rtl/flag_bus_seq.sv
// Module: flag_bus_seq (top)
// Drives one quadrant of active-low almost-full flags onto a shared bus.
// The quadrant comes either from a strobed address (direct) or from a token-ring
// rotation (polled).
// Assumes: mode_polled and is_master are static between resets.
module flag_bus_seq
    import flagseq_pkg::*;
#(
    parameter int QUEUES = 32,
    parameter int QUADS  = 4,
    parameter int GRP    = QUEUES / QUADS,
    parameter int ADDR_W = idx_bits(QUEUES),
    parameter int QSEL_W = idx_bits(QUADS)
) (
    input  logic              clk_w,
    input  logic              rst_n,
    input  logic [QUEUES-1:0] afull_n,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              strobe,
    input  logic              mode_polled,
    input  logic              is_master,
    input  logic              tok_in,
    output logic [GRP-1:0]    flag_bus,
    output logic              flag_oe,
    output logic              sync,
    output logic              tok_out
);
    fmode_e            mode;
    logic              p_act;
    logic [QSEL_W-1:0] p_idx;
    logic [QSEL_W-1:0] d_sel;
    logic              show;
    logic [QSEL_W-1:0] quad;

    assign mode = fmode_e'(mode_polled);

    fbs_poll_seq #(.QUADS(QUADS), .QSEL_W(QSEL_W)) u_poll (
        .clk(clk_w), .rst_n(rst_n), .en(mode == MODE_POLLED),
        .is_master(is_master), .tok_in(tok_in),
        .nxt_act(p_act), .nxt_idx(p_idx), .sync(sync), .tok_out(tok_out)
    );

    fbs_dir_sel #(.ADDR_W(ADDR_W), .QSEL_W(QSEL_W)) u_dir (
        .clk(clk_w), .rst_n(rst_n), .en(mode == MODE_DIRECT),
        .strobe(strobe), .wr_addr(wr_addr), .nxt_sel(d_sel)
    );

    // Quadrant source and bus ownership by mode.
    always_comb begin
        if (mode == MODE_POLLED) begin
            show = p_act;
            quad = p_idx;
        end else begin
            show = 1'b1;
            quad = d_sel;
        end
    end

    fbs_flag_mux #(.QUEUES(QUEUES), .QUADS(QUADS), .QSEL_W(QSEL_W), .GRP(GRP)) u_mux (
        .clk(clk_w), .rst_n(rst_n), .afull_n(afull_n), .show(show), .quad(quad),
        .flag_bus(flag_bus), .flag_oe(flag_oe)
    );
endmodule

// File: rtl/flag_bus_seq_chk.sv
// Module: flag_bus_seq_chk
// Timing properties of the sequencer, bound to the top module.
// Assumes: the top's default quadrant layout (address top bits name quadrant).
module flag_bus_seq_chk #(
    parameter int QUEUES = 32,
    parameter int QUADS  = 4,
    parameter int GRP    = QUEUES / QUADS,
    parameter int ADDR_W = 5,
    parameter int QSEL_W = 2
) (
    input logic              clk_w,
    input logic              rst_n,
    input logic [QUEUES-1:0] afull_n,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              strobe,
    input logic              mode_polled,
    input logic              tok_in,
    input logic [GRP-1:0]    flag_bus,
    input logic              flag_oe,
    input logic              sync,
    input logic              tok_out
);
    logic [QUEUES-1:0] prev_fl;
    logic [QSEL_W-1:0] prev_q;
    logic [GRP-1:0]    exp_slice;

    // Capture last cycle's flags and address quadrant.
    always_ff @(posedge clk_w) begin
        prev_fl <= afull_n;
        prev_q  <= wr_addr[ADDR_W-1 -: QSEL_W];
    end
    assign exp_slice = GRP'(prev_fl >> (int'(prev_q) * GRP));

    p_dir_load_r2: assert property (@(posedge clk_w) disable iff (!rst_n)
        (!mode_polled && strobe) |=> (flag_bus == exp_slice && flag_oe));
    p_dir_quiet_r4: assert property (@(posedge clk_w) disable iff (!rst_n)
        !mode_polled |-> (!sync && !tok_out));
    p_markers_excl_r7: assert property (@(posedge clk_w) disable iff (!rst_n)
        $onehot0({sync, tok_out}));
    p_sync_driven_r7: assert property (@(posedge clk_w) disable iff (!rst_n)
        (sync || tok_out) |-> flag_oe);
    p_tok_restart_r9: assert property (@(posedge clk_w) disable iff (!rst_n)
        (mode_polled && tok_in) |=> sync);
    p_step_on_r6: assert property (@(posedge clk_w) disable iff (!rst_n)
        (sync && !tok_in) |=> (flag_oe && !sync));
    p_idle_bus_r10: assert property (@(posedge clk_w) disable iff (!rst_n)
        (mode_polled && !flag_oe) |-> (flag_bus == '1));
    p_release_r10: assert property (@(posedge clk_w) disable iff (!rst_n)
        (tok_out && !tok_in) |=> !flag_oe);
endmodule

bind flag_bus_seq flag_bus_seq_chk #(
    .QUEUES(QUEUES), .QUADS(QUADS), .GRP(GRP), .ADDR_W(ADDR_W), .QSEL_W(QSEL_W)
) u_chk (
    .clk_w(clk_w), .rst_n(rst_n), .afull_n(afull_n), .wr_addr(wr_addr),
    .strobe(strobe), .mode_polled(mode_polled), .tok_in(tok_in),
    .flag_bus(flag_bus), .flag_oe(flag_oe), .sync(sync), .tok_out(tok_out)
);

// File: tb/test_flag_bus_seq.sv
`timescale 1ns/100ps
module test_flag_bus_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] afull_n = '1;
    logic [4:0]  wr_addr = '0;
    logic        strobe = 1'b0, mode_polled = 1'b0, is_master = 1'b1;
    logic        tok_drv = 1'b0, loop_en = 1'b0;
    logic [7:0]  flag_bus;
    logic        flag_oe, sync, tok_out;
    wire         tok_in = loop_en ? tok_out : tok_drv;

    flag_bus_seq i_flag_bus_seq (
        .clk_w(clk), .rst_n(rst_n), .afull_n(afull_n), .wr_addr(wr_addr),
        .strobe(strobe), .mode_polled(mode_polled), .is_master(is_master),
        .tok_in(tok_in), .flag_bus(flag_bus), .flag_oe(flag_oe),
        .sync(sync), .tok_out(tok_out)
    );

    always #2.5 clk = ~clk;

    // Behavioural reference model state.
    int        m_act = 0, m_idx = 0, m_sel = 0, m_boot = 1;
    logic [7:0] m_bus = 8'hFF;
    logic      m_oe = 1'b0;
    bit        chk_en = 0, done = 0;
    int        n_chk = 0, n_fail = 0;
    string     tag = "R1";

    always @(posedge clk) begin
        logic t;
        t = loop_en ? (mode_polled && m_act == 1 && m_idx == 3) : tok_drv;
        if (!rst_n) begin
            m_act = 0; m_idx = 0; m_sel = 0; m_boot = 1; m_bus = 8'hFF; m_oe = 1'b0;
        end else begin
            if (mode_polled) begin
                if (t || (m_boot == 1 && is_master)) begin m_act = 1; m_idx = 0; end
                else if (m_act == 1) begin
                    if (m_idx == 3) m_act = 0; else m_idx = m_idx + 1;
                end
                m_bus = (m_act == 1) ? afull_n[m_idx*8 +: 8] : 8'hFF;
                m_oe  = (m_act == 1);
            end else begin
                if (strobe) m_sel = int'(wr_addr[4:3]);
                m_bus = afull_n[m_sel*8 +: 8];
                m_oe  = 1'b1;
            end
            m_boot = 0;
        end
    end

    task automatic check(string what, string rq, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s [phase %s] %s: actual %h expected %h", rq, tag, what, act, exp);
        end
    endtask

    // Compare against the model every cycle, away from the active edge.
    always @(negedge clk) begin
        if (chk_en && !done) begin
            logic xs, xt;
            xs = mode_polled && m_act == 1 && m_idx == 0;
            xt = mode_polled && m_act == 1 && m_idx == 3;
            if (!rst_n) begin
                check("flag_bus", "R1", flag_bus, m_bus);
                check("flag_oe", "R1", {7'd0, flag_oe}, {7'd0, m_oe});
                check("sync", "R1", {7'd0, sync}, 8'd0);
                check("tok_out", "R1", {7'd0, tok_out}, 8'd0);
            end else begin
                check("flag_bus", mode_polled ? "R6" : "R2", flag_bus, m_bus);
                check("flag_oe", mode_polled ? "R10" : "R3", {7'd0, flag_oe}, {7'd0, m_oe});
                check("sync", mode_polled ? "R7" : "R4", {7'd0, sync}, {7'd0, xs});
                check("tok_out", mode_polled ? "R8" : "R4", {7'd0, tok_out}, {7'd0, xt});
            end
        end
    end

    task automatic cyc(int n);
        repeat (n) begin
            @(posedge clk); #1;
            afull_n = $urandom;
        end
    endtask

    task automatic do_reset(bit polled, bit master, bit loop);
        rst_n = 1'b0; tag = "R1";
        mode_polled = polled; is_master = master; loop_en = loop; tok_drv = 1'b0; strobe = 1'b0;
        cyc(1); chk_en = 1; cyc(2);
        rst_n = 1'b1;
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        // Direct mode: strobed selections, then held quadrant (R2, R3, R4).
        do_reset(1'b0, 1'b1, 1'b0);
        tag = "R3"; cyc(3);
        tag = "R2";
        for (int i = 0; i < 24; i++) begin
            strobe = (i % 3 != 2); wr_addr = 5'($urandom);
            cyc(1);
        end
        strobe = 1'b0; tag = "R3"; cyc(10);

        // Polled master, no loop: one rotation then idle; strobes ignored (R5, R6, R10).
        do_reset(1'b1, 1'b1, 1'b0);
        tag = "R5";
        for (int i = 0; i < 12; i++) begin
            strobe = $urandom; wr_addr = 5'($urandom);
            cyc(1);
        end
        strobe = 1'b0;
        // Token mid-rotation and while idle (R9).
        tag = "R9";
        tok_drv = 1'b1; cyc(1); tok_drv = 1'b0; cyc(2);
        tok_drv = 1'b1; cyc(1); tok_drv = 1'b0; cyc(8);

        // Single-device loopback: period four (R11).
        do_reset(1'b1, 1'b1, 1'b1);
        tag = "R11"; cyc(30);

        // Non-master stays off the bus until the token comes (R10, R9).
        do_reset(1'b1, 1'b0, 1'b0);
        tag = "R10"; cyc(8);
        tag = "R9"; tok_drv = 1'b1; cyc(1); tok_drv = 1'b0; cyc(7);

        done = 1;
        summary();
        $finish;
    end

    initial begin
        #(200000 * 5.0);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule